// File: doc/BRIEF.md
# Four-Axis Joystick Position Digitiser

This block turns four joystick axis positions into digital counts. Each axis reaches the block as a digital timing input. The input is high while the axis's external one-shot is timing and falls when that timing ends. When a measurement starts, every enabled axis counter is cleared. Each counter then adds one on every prescaled tick while its input stays high. It stops the first time its input is seen low, or when it reaches a fixed maximum count. The ready flag rises once every enabled counter has stopped.

Software reaches the block through a small byte-addressed register window with a 16-bit data path. A write to the value port starts a one-shot measurement. A continuous mode starts a new measurement on its own after a programmable number of clock cycles. An interrupt can be raised on each completed measurement. A compatibility port reads back the raw timing inputs and the button inputs. Writing that port can also raise an interrupt when at least one axis is enabled.

Top module: `gp_digitiser`

## Requirements
- R1: After reset, the axis configuration register (address 1), the value port (address 2) and the hardware configuration register (address 4) all read 0, and `irq` and `legacy_en` are low.
- R2: Starting a measurement clears the counters of the enabled axes and drives the ready flag (address 1 bit 7) low. Counters of disabled axes keep their values. Axis enables sit in address 1 bits 3:0, with bit i for axis i.
- R3: A write of any value to address 2 starts a measurement. Each enabled counter adds one per prescaled tick while its timing input is high, and stops for good the first time that input is low.
- R4: Address 4 bits 2:1 set the count rate. Code 0 counts every clock, code 1 every 2nd clock, code 2 every 20th clock and code 3 every 200th clock, with the first tick falling a full period after the start.
- R5: The ready flag rises once all enabled counters have stopped. A counter whose input stays high stops at the maximum count MAX_CNT.
- R6: Reading address 2 returns the count of the axis chosen by address 1 bits 5:4, with code k selecting axis k.
- R7: When address 4 bit 0 is set, each completed measurement raises `irq`. A write of any value to address 5 clears `irq`. With bit 0 clear, a completed measurement leaves `irq` low.
- R8: A write to address 0 raises `irq` only when address 4 bit 0 is set and at least one axis is enabled.
- R9: Reading address 0 returns the timing inputs in bits 3:0 and the button inputs in bits 7:4.
- R10: Address 4 bits 7:4 always read 0, and address 4 bit 3 drives the `legacy_en` output.
- R11: With address 1 bit 6 set, a measurement starts by itself every N+1 clock cycles, where N is the value at address 6. Each completion in this mode raises `irq` when the interrupt is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| axis_in | input | 4 | Axis timing inputs, high while timing |
| btn_in | input | 4 | Button inputs |
| irq | output | 1 | Interrupt request, level |
| legacy_en | output | 1 | Compatibility address enable |

## Verification
The assertions check four things on every cycle. A counter only ever holds or steps by one between starts. A counter never passes its maximum. A disabled counter survives a start unchanged. The ready flag drops after a start and rises only when no counter is running. They also check that `irq` rises only with the interrupt enable set, and that automatic starts never fire on consecutive cycles.

The directed scenarios cover what needs known stimulus to judge. These are the exact counts at each prescaler code, the per-axis stop times read through the selector, and saturation. They also cover the interrupt and acknowledge behaviour, the gating of the compatibility-port interrupt, the raw input readback, and the exact restart period in continuous mode.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int NAX = 4;
  localparam int AW  = 3;
  localparam int DW  = 16;

  localparam logic [AW-1:0] A_COMPAT = 3'd0;
  localparam logic [AW-1:0] A_AXCFG  = 3'd1;
  localparam logic [AW-1:0] A_VALUE  = 3'd2;
  localparam logic [AW-1:0] A_HWCFG  = 3'd4;
  localparam logic [AW-1:0] A_ACK    = 3'd5;
  localparam logic [AW-1:0] A_INTV   = 3'd6;

  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_HALF = 2'd1,
    RATE_D20  = 2'd2,
    RATE_D200 = 2'd3
  } rate_e;

  typedef struct packed {
    logic       cont;
    logic [1:0] sel;
    logic [3:0] en;
  } axcfg_t;

  typedef struct packed {
    logic  compat;
    rate_e rate;
    logic  irq_en;
  } hwcfg_t;
endpackage

// File: rtl/gp_prescaler.sv
module gp_prescaler
  import gp_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 20,
  parameter int DIV_C = 200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  rate_e rate,
  output logic  tick
);
  localparam int PW = $clog2(DIV_C) + 1;

  logic [PW-1:0] pre_q, pre_d, lim;

  always_comb begin
    unique case (rate)
      RATE_FULL: lim = '0;
      RATE_HALF: lim = PW'(DIV_A - 1);
      RATE_D20:  lim = PW'(DIV_B - 1);
      default:   lim = PW'(DIV_C - 1);
    endcase
  end

  assign tick = (pre_q >= lim);

  always_comb begin
    if (clr)       pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: after a clear the phase restarts at zero
  p_clr_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/gp_axis_ctr.sv
module gp_axis_ctr #(
  parameter int CNT_W   = 16,
  parameter int MAX_CNT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             sense,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = count;
    run_d  = running;
    cnt_ce = 1'b0;
    if (start) begin
      run_d = en;
      if (en) begin
        cnt_d  = '0;
        cnt_ce = 1'b1;
      end
    end else if (running) begin
      if (!sense || count == CMAX) begin
        run_d = 1'b0;
      end else if (tick) begin
        cnt_d  = count + 1'b1;
        cnt_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      running <= run_d;
      if (cnt_ce) count <= cnt_d;
    end
  end

  // R3: between starts a count only holds or steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count == $past(count)) || (count == $past(count) + 1'b1));
  // R5: never beyond the maximum
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CMAX);
  // R2: disabled axis keeps its value across a start
  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !en) |=> $stable(count));
endmodule

// File: rtl/gp_interval.sv
module gp_interval #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [IW-1:0] limit,
  output logic          fire
);
  logic [IW-1:0] icnt_q, icnt_d;

  assign fire = enable && (icnt_q == limit);

  always_comb begin
    if (!enable)   icnt_d = '0;
    else if (fire) icnt_d = '0;
    else           icnt_d = icnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icnt_q <= '0;
    else        icnt_q <= icnt_d;
  end

  // R11: automatic starts are spaced when the interval is nonzero
  p_fire_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && limit != '0) |=> !fire);
endmodule

// File: rtl/gp_digitiser.sv
module gp_digitiser
  import gp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MAX_CNT  = 1000,
  parameter int DIV_A    = 2,
  parameter int DIV_B    = 20,
  parameter int DIV_C    = 200,
  parameter int IW       = 16,
  parameter int INTV_RST = 999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic [3:0]    axis_in,
  input  logic [3:0]    btn_in,
  output logic          irq,
  output logic          legacy_en
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  axcfg_t        axcfg_q, axcfg_d;
  hwcfg_t        hwcfg_q, hwcfg_d;
  logic [IW-1:0] intv_q, intv_d;
  logic          ready_q, ready_d;
  logic          busy_q, busy_d;
  logic          irq_q, irq_d;

  logic wr_compat, wr_axcfg, wr_value, wr_hwcfg, wr_ack, wr_intv;
  assign wr_compat = wr_en && (addr == A_COMPAT);
  assign wr_axcfg  = wr_en && (addr == A_AXCFG);
  assign wr_value  = wr_en && (addr == A_VALUE);
  assign wr_hwcfg  = wr_en && (addr == A_HWCFG);
  assign wr_ack    = wr_en && (addr == A_ACK);
  assign wr_intv   = wr_en && (addr == A_INTV);

  logic auto_fire, start, tick, all_stop, done;
  logic [NAX-1:0]   running;
  logic [CNT_W-1:0] count [NAX];

  assign start    = wr_value || auto_fire;
  assign all_stop = ~|running;
  assign done     = busy_q && all_stop && !start;

  gp_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(srst_n), .clr(start), .rate(hwcfg_q.rate), .tick(tick)
  );

  gp_interval #(.IW(IW)) u_intv (
    .clk(clk), .rst_n(srst_n), .enable(axcfg_q.cont), .limit(intv_q),
    .fire(auto_fire)
  );

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    gp_axis_ctr #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_ctr (
      .clk(clk), .rst_n(srst_n), .start(start), .en(axcfg_q.en[g]),
      .sense(axis_in[g]), .tick(tick), .count(count[g]), .running(running[g])
    );
  end

  // next state
  always_comb begin
    axcfg_d = axcfg_q;
    hwcfg_d = hwcfg_q;
    intv_d  = intv_q;
    ready_d = ready_q;
    busy_d  = busy_q;
    irq_d   = irq_q;

    if (wr_axcfg) begin
      axcfg_d.en   = wdata[3:0];
      axcfg_d.sel  = wdata[5:4];
      axcfg_d.cont = wdata[6];
    end
    if (wr_hwcfg) begin
      hwcfg_d.irq_en = wdata[0];
      hwcfg_d.rate   = rate_e'(wdata[2:1]);
      hwcfg_d.compat = wdata[3];
    end
    if (wr_intv) intv_d = wdata[IW-1:0];

    if (start) begin
      ready_d = 1'b0;
      busy_d  = 1'b1;
    end else if (done) begin
      ready_d = 1'b1;
      busy_d  = 1'b0;
    end

    if ((done && hwcfg_q.irq_en) ||
        (wr_compat && hwcfg_q.irq_en && |axcfg_q.en))
      irq_d = 1'b1;
    else if (wr_ack)
      irq_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      axcfg_q <= '0;
      hwcfg_q <= '0;
      intv_q  <= IW'(INTV_RST);
      ready_q <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      axcfg_q <= axcfg_d;
      hwcfg_q <= hwcfg_d;
      intv_q  <= intv_d;
      ready_q <= ready_d;
      busy_q  <= busy_d;
      irq_q   <= irq_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_COMPAT: rdata[7:0] = {btn_in, axis_in};
      A_AXCFG:  rdata[7:0] = {ready_q, axcfg_q.cont, axcfg_q.sel, axcfg_q.en};
      A_VALUE:  rdata      = 16'(count[axcfg_q.sel]);
      A_HWCFG:  rdata[3:0] = {hwcfg_q.compat, hwcfg_q.rate, hwcfg_q.irq_en};
      A_INTV:   rdata      = 16'(intv_q);
      default:  rdata      = '0;
    endcase
  end

  assign irq       = irq_q;
  assign legacy_en = hwcfg_q.compat;

  // R2: a start always drops the ready flag
  p_start_clears_ready_r2: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> !ready_q);
  // R5: ready rises only with no counter running
  p_ready_when_stopped_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(ready_q) |-> ($past(running) == '0));
  // R7: interrupt only when enabled
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_q) |-> $past(hwcfg_q.irq_en));
endmodule

// File: tb/sim_gp_digitiser.sv
module sim_gp_digitiser;
  localparam int MAXC = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  axis_in;
  logic [3:0]  btn_in;
  logic        irq;
  logic        legacy_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gp_digitiser #(.MAX_CNT(MAXC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .axis_in(axis_in), .btn_in(btn_in), .irq(irq),
    .legacy_en(legacy_en)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_ready(input int maxc, output bit ok);
    logic [15:0] v;
    ok = 0;
    for (int i = 0; i < maxc; i++) begin
      rd(3'd1, v);
      if (v[7]) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd1, v); chk("R1 axcfg", v, 0);
    rd(3'd2, v); chk("R1 value", v, 0);
    rd(3'd4, v); chk("R1 hwcfg", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 legacy_en", legacy_en, 0);
  endtask

  task automatic t_single();
    logic [15:0] v; bit ok;
    wr(3'd4, 16'h0000);
    wr(3'd1, 16'h0001);
    axis_in = 4'hF;
    wr(3'd2, 16'h0000);
    repeat (37) @(negedge clk);
    axis_in = 4'h0;
    wait_ready(50, ok);
    chk("R5 ready after stop", ok, 1);
    rd(3'd2, v); chk("R3 count div1", v, 37);
  endtask

  task automatic t_multi_sel();
    logic [15:0] v; bit ok;
    int tt[4] = '{10, 20, 30, 40};
    wr(3'd1, 16'h000F);
    axis_in = 4'hF;
    wr(3'd2, 16'h0000);
    for (int c = 1; c <= 45; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (c == tt[i]) axis_in[i] = 1'b0;
    end
    wait_ready(20, ok);
    chk("R5 ready all axes", ok, 1);
    for (int i = 0; i < 4; i++) begin
      wr(3'd1, 16'(16'h000F | (i << 4)));
      rd(3'd2, v); chk("R6 select axis", v, tt[i]);
    end
  endtask

  task automatic t_disabled_hold();
    logic [15:0] v; bit ok;
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0000);
    rd(3'd1, v); chk("R2 ready low after start", v[7], 0);
    wait_ready(20, ok);
    rd(3'd2, v); chk("R2 enabled cleared", v, 0);
    wr(3'd1, 16'h0031);
    rd(3'd2, v); chk("R2 disabled kept", v, 40);
  endtask

  task automatic t_prescale();
    logic [15:0] v; bit ok;
    int dv[4] = '{1, 2, 20, 200};
    for (int r = 1; r < 4; r++) begin
      wr(3'd4, 16'(r << 1));
      wr(3'd1, 16'h0001);
      axis_in = 4'h1;
      wr(3'd2, 16'h0000);
      repeat (450) @(negedge clk);
      axis_in = 4'h0;
      wait_ready(50, ok);
      rd(3'd2, v); chk("R4 prescaled count", v, 450 / dv[r]);
    end
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_saturate();
    logic [15:0] v; bit ok;
    wr(3'd1, 16'h0001);
    axis_in = 4'h1;
    wr(3'd2, 16'h0000);
    wait_ready(400, ok);
    chk("R5 ready at max", ok, 1);
    rd(3'd2, v); chk("R5 saturated", v, MAXC);
    axis_in = 4'h0;
  endtask

  task automatic t_irq();
    bit ok;
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0003);
    wr(3'd2, 16'h0000);
    wait_ready(20, ok);
    @(negedge clk); chk("R7 irq on completion", irq, 1);
    wr(3'd5, 16'h0000);
    chk("R7 irq acked", irq, 0);
    wr(3'd4, 16'h0000);
    wr(3'd2, 16'h0000);
    wait_ready(20, ok);
    @(negedge clk); chk("R7 no irq when disabled", irq, 0);
  endtask

  task automatic t_compat();
    logic [15:0] v;
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h00FF);
    chk("R8 no irq without axis", irq, 0);
    wr(3'd1, 16'h0004);
    wr(3'd0, 16'h00FF);
    chk("R8 irq on compat write", irq, 1);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h00FF);
    chk("R8 no irq with enable off", irq, 0);
    axis_in = 4'b1010; btn_in = 4'b0110;
    rd(3'd0, v); chk("R9 raw readback", v, 16'h006A);
    axis_in = 4'h0; btn_in = 4'h0;
  endtask

  task automatic t_hwcfg();
    logic [15:0] v;
    wr(3'd4, 16'h00FF);
    rd(3'd4, v); chk("R10 high bits zero", v, 16'h000F);
    chk("R10 legacy_en", legacy_en, 1);
    wr(3'd4, 16'h0000);
    chk("R10 legacy_en off", legacy_en, 0);
    wr(3'd5, 16'h0000);
  endtask

  task automatic t_cont();
    int t1, t2;
    wr(3'd6, 16'd49);
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'h0041);
    t1 = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) begin t1 = cyc; break; end
    end
    wr(3'd5, 16'h0000);
    t2 = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) begin t2 = cyc; break; end
    end
    chk("R11 auto irq seen", (t1 >= 0 && t2 >= 0), 1);
    chk("R11 restart period", t2 - t1, 50);
    wr(3'd1, 16'h0000);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0000);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    axis_in = 4'h0; btn_in = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi_sel();
    t_disabled_hold();
    t_prescale();
    t_saturate();
    t_irq();
    t_compat();
    t_hwcfg();
    t_cont();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule